// File: doc/BRIEF.md
# Four-Level Blocked Tile Address Generator

This block produces a stream of word addresses that reads a row-major matrix buffer and hands it out as contiguous small sub-blocks, the order a blocked multiply-accumulate engine expects. Four nested counting dimensions each have a repeat count (wrap) and an address step (stride). All dimensions are programmed while the generator is idle. A start pulse together with a base address then launches one transfer. The generator emits one address per accepted handshake and marks the final address with a last flag.

With dimension 0 set to wrap s and stride 1, dimension 1 to wrap r and stride k, dimension 2 to wrap k/s and stride s, and dimension 3 to wrap m/r and stride r·k, an m×k row-major source comes out as r×s blocks. Other settings of the same four pairs cover the k×n matrix cut into s×t blocks, and the reverse scatter of r×t blocks into a row-major m×n result. All addresses and strides are in 4-byte words. Element sizes other than four bytes are scaled before the values are programmed.

The control is a two-state machine. In `ST_IDLE` the configuration is open and the output is quiet. On the transition taken when start is seen, the counters are cleared and the base is captured, and the machine enters `ST_STREAM`. It stays in `ST_STREAM` while addresses are offered. The transition taken when the last address is accepted returns it to `ST_IDLE`.

Top module: `tile_addr_gen`

## Requirements
- R1: After reset the block is idle: `busy`, `out_valid` and `out_last` are 0.
- R2: A `start` pulse while idle makes `out_valid` 1 in the next cycle, with `out_addr` equal to the `base_addr` sampled with `start`.
- R3: Dimension select 0 is the innermost, fastest-moving dimension and select 3 is the outermost. Each address equals base plus the sum over the four dimensions of index × stride. A dimension's index advances only when every inner dimension is at its final index, and it then resets to 0 once it has passed its own final index.
- R4: While `out_valid` is 1 and `out_ready` is 0, `out_addr` and `out_last` hold their values.
- R5: A transfer offers exactly the product of the four effective wraps addresses, and `out_last` is 1 only on the final one.
- R6: In the cycle after the last address is accepted, `out_valid` and `busy` are 0, and they stay 0 whatever `out_ready` does until the next `start`.
- R7: A programmed wrap of 0 behaves as a wrap of 1, so that dimension contributes a single step.
- R8: Configuration writes (`cfg_we`) made while `busy` is 1 are ignored. Neither the running transfer nor later transfers see them.
- R9: A `start` pulse while `busy` is 1 is ignored and does not restart the sequence or change the base.
- R10: Address arithmetic wraps modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Dimension to write (0 innermost, 3 outermost) |
| cfg_wrap | input | WRAP_W | Repeat count of the selected dimension (0 means 1) |
| cfg_stride | input | ADDR_W | Word step of the selected dimension |
| start | input | 1 | Begin a transfer (honoured only while idle) |
| base_addr | input | ADDR_W | Word base address captured with start |
| busy | output | 1 | Transfer in progress |
| out_valid | output | 1 | An address is offered |
| out_ready | input | 1 | Consumer accepts the offered address |
| out_addr | output | ADDR_W | Offered word address |
| out_last | output | 1 | Offered address is the final one of the transfer |

## Verification
The first address appears one cycle after the edge that samples `start`. Each later address replaces its predecessor one cycle after the edge that accepts it. `out_valid` falls one cycle after the edge that accepts the last address. The bench drives inputs on the falling edge and compares the outputs on the next falling edge against a queue built from four nested loops. Because every comparison lands exactly one register stage after the edge that caused it, a stall, a skipped address or a late idle shows up as a mismatch at that very cycle.

// File: rtl/tag_pkg.sv
package tag_pkg;
    localparam int DIMS  = 4;
    localparam int SEL_W = $clog2(DIMS);

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_STREAM = 1'b1
    } tag_state_e;
endpackage

// File: rtl/tag_cfg_bank.sv
module tag_cfg_bank
    import tag_pkg::*;
#(
    parameter int WRAP_W = 8,
    parameter int ADDR_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_open,
    input  logic                          cfg_we,
    input  logic [SEL_W-1:0]              cfg_sel,
    input  logic [WRAP_W-1:0]             cfg_wrap,
    input  logic [ADDR_W-1:0]             cfg_stride,
    output logic [DIMS-1:0][WRAP_W-1:0]   eff_wrap,
    output logic [DIMS-1:0][ADDR_W-1:0]   stride
);
    logic [DIMS-1:0][WRAP_W-1:0] wrap_q;
    logic [DIMS-1:0][ADDR_W-1:0] stride_q;

    genvar d;
    generate
        for (d = 0; d < DIMS; d++) begin : g_dim
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    wrap_q[d]   <= '0;
                    stride_q[d] <= '0;
                end else if (cfg_we && wr_open && (cfg_sel == SEL_W'(d))) begin
                    wrap_q[d]   <= cfg_wrap;
                    stride_q[d] <= cfg_stride;
                end
            end

            // a zero wrap counts as a single step
            always_comb begin
                eff_wrap[d] = (wrap_q[d] == '0) ? WRAP_W'(1) : wrap_q[d];
            end
            assign stride[d] = stride_q[d];
        end
    endgenerate
endmodule

// File: rtl/tag_dim_stage.sv
module tag_dim_stage #(
    parameter int WRAP_W = 8,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic [WRAP_W-1:0] wrap,
    input  logic [ADDR_W-1:0] stride,
    output logic              at_end,
    output logic [ADDR_W-1:0] offset
);
    logic [WRAP_W-1:0] idx_q;
    logic [ADDR_W-1:0] off_q;
    logic [WRAP_W-1:0] final_idx;

    assign final_idx = wrap - WRAP_W'(1);
    assign at_end    = (idx_q >= final_idx);
    assign offset    = off_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            off_q <= '0;
        end else if (clear) begin
            idx_q <= '0;
            off_q <= '0;
        end else if (step) begin
            if (at_end) begin
                idx_q <= '0;
                off_q <= '0;
            end else begin
                idx_q <= idx_q + WRAP_W'(1);
                off_q <= off_q + stride;
            end
        end
    end
endmodule

// File: rtl/tag_addr_sum.sv
module tag_addr_sum
    import tag_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0]            base,
    input  logic [DIMS-1:0][ADDR_W-1:0]  offsets,
    output logic [ADDR_W-1:0]            addr
);
    always_comb begin
        addr = base;
        for (int d = 0; d < DIMS; d++) begin
            addr = addr + offsets[d];
        end
    end
endmodule

// File: rtl/tag_ctrl_fsm.sv
module tag_ctrl_fsm
    import tag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic fire,
    input  logic all_end,
    output logic load,
    output logic busy,
    output logic cfg_open
);
    tag_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start)            state_d = ST_STREAM;
            ST_STREAM: if (fire && all_end)  state_d = ST_IDLE;
            default:                         state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load     = 1'b0;
        busy     = 1'b0;
        cfg_open = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cfg_open = 1'b1;
                load     = start;
            end
            ST_STREAM: busy = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/tile_addr_gen.sv
module tile_addr_gen
    import tag_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int WRAP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [WRAP_W-1:0] cfg_wrap,
    input  logic [ADDR_W-1:0] cfg_stride,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    output logic              busy,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_last
);
    logic                         load, cfg_open, fire, all_end;
    logic [DIMS-1:0][WRAP_W-1:0]  eff_wrap;
    logic [DIMS-1:0][ADDR_W-1:0]  stride;
    logic [DIMS-1:0][ADDR_W-1:0]  offsets;
    logic [DIMS-1:0]              at_end;
    logic [DIMS-1:0]              step;
    logic [ADDR_W-1:0]            base_q;

    tag_ctrl_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .fire     (fire),
        .all_end  (all_end),
        .load     (load),
        .busy     (busy),
        .cfg_open (cfg_open)
    );

    tag_cfg_bank #(.WRAP_W(WRAP_W), .ADDR_W(ADDR_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_open    (cfg_open),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wrap   (cfg_wrap),
        .cfg_stride (cfg_stride),
        .eff_wrap   (eff_wrap),
        .stride     (stride)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    base_q <= '0;
        else if (load) base_q <= base_addr;
    end

    assign fire    = busy & out_ready;
    assign all_end = &at_end;
    assign step[0] = fire;

    genvar d;
    generate
        for (d = 0; d < DIMS; d++) begin : g_nest
            tag_dim_stage #(.WRAP_W(WRAP_W), .ADDR_W(ADDR_W)) u_stage (
                .clk    (clk),
                .rst_n  (rst_n),
                .clear  (load),
                .step   (step[d]),
                .wrap   (eff_wrap[d]),
                .stride (stride[d]),
                .at_end (at_end[d]),
                .offset (offsets[d])
            );
            if (d < DIMS - 1) begin : g_carry
                assign step[d+1] = step[d] & at_end[d];
            end
        end
    endgenerate

    tag_addr_sum #(.ADDR_W(ADDR_W)) u_sum (
        .base    (base_q),
        .offsets (offsets),
        .addr    (out_addr)
    );

    assign out_valid = busy;
    assign out_last  = busy & all_end;
endmodule

// File: rtl/tile_addr_gen_chk.sv
module tile_addr_gen_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [ADDR_W-1:0] base_addr,
    input logic              busy,
    input logic              out_valid,
    input logic              out_ready,
    input logic [ADDR_W-1:0] out_addr,
    input logic              out_last
);
    // R1: nothing is offered while the block is idle
    a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!out_valid && !out_last));

    // R2: a start seen while idle produces the base address next cycle
    a_r2_first_is_base: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (out_valid && out_addr == $past(base_addr)));

    // R4: a stalled offer holds its address and last flag
    a_r4_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_last)));

    // R5: last only accompanies an offered address
    a_r5_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    // R6: accepting the last address ends the transfer
    a_r6_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> !out_valid);

    // R6: the offer only ends through an accepted last address
    a_r6_no_early_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !(out_ready && out_last)) |=> out_valid);
endmodule

bind tile_addr_gen tile_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .base_addr (base_addr),
    .busy      (busy),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_addr  (out_addr),
    .out_last  (out_last)
);

// File: tb/tile_addr_gen_test.sv
module tile_addr_gen_test;
    localparam int ADDR_W = 16;
    localparam int WRAP_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [1:0]        cfg_sel = '0;
    logic [WRAP_W-1:0] cfg_wrap = '0;
    logic [ADDR_W-1:0] cfg_stride = '0;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] base_addr = '0;
    logic              busy, out_valid, out_last;
    logic              out_ready = 1'b0;
    logic [ADDR_W-1:0] out_addr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    int m_wrap[4];
    int m_stride[4];
    int q[$];

    always #5 clk = ~clk;

    tile_addr_gen #(.ADDR_W(ADDR_W), .WRAP_W(WRAP_W)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wrap(cfg_wrap), .cfg_stride(cfg_stride), .start(start),
        .base_addr(base_addr), .busy(busy), .out_valid(out_valid),
        .out_ready(out_ready), .out_addr(out_addr), .out_last(out_last)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            finish_run();
        end
    end

    task automatic write_dim(input int sel, input int wrap, input int stride);
        @(negedge clk);
        cfg_we = 1; cfg_sel = 2'(sel); cfg_wrap = WRAP_W'(wrap); cfg_stride = ADDR_W'(stride);
        m_wrap[sel] = wrap; m_stride[sel] = stride;
        @(negedge clk);
        cfg_we = 0;
    endtask

    // reference: four nested loops, outermost first (R3, R7)
    task automatic build(input int base);
        int w[4];
        q.delete();
        for (int d = 0; d < 4; d++) w[d] = (m_wrap[d] == 0) ? 1 : m_wrap[d];
        for (int i3 = 0; i3 < w[3]; i3++)
            for (int i2 = 0; i2 < w[2]; i2++)
                for (int i1 = 0; i1 < w[1]; i1++)
                    for (int i0 = 0; i0 < w[0]; i0++)
                        q.push_back((base + i3*m_stride[3] + i2*m_stride[2]
                                      + i1*m_stride[1] + i0*m_stride[0]) & 16'hFFFF);
    endtask

    // mode 0: always ready, 1/2: stall patterns; inject 1: cfg write while busy, 2: restart while busy
    task automatic run(input int base, input int mode, input int inject, input string req);
        int cyc;
        int expn;
        bit rdy;
        bit prev_rdy;
        int prev_addr;
        build(base);
        expn = q.size();
        @(negedge clk);
        start = 1; base_addr = ADDR_W'(base);
        @(negedge clk);
        start = 0;
        chk(out_valid == 1 && int'(out_addr) == q[0], "R2", int'(out_addr), q[0]);
        cyc = 0; prev_rdy = 1; prev_addr = 0;
        while (q.size() > 0 && cyc < 4000) begin
            chk(out_valid == 1, {req, " valid"}, out_valid, 1);
            chk(int'(out_addr) == q[0], {req, " addr"}, int'(out_addr), q[0]);
            chk(out_last == (q.size() == 1), "R5 last", out_last, q.size() == 1);
            if (!prev_rdy) chk(int'(out_addr) == prev_addr, "R4 hold", int'(out_addr), prev_addr);
            case (mode)
                1: rdy = (cyc % 3) != 1;
                2: rdy = ((cyc * 7) % 5) < 2;
                default: rdy = 1;
            endcase
            out_ready = rdy;
            if (cyc == 3 && inject == 1) begin
                cfg_we = 1; cfg_sel = 2'd0; cfg_wrap = 8'd5; cfg_stride = 16'd9;
            end
            if (cyc == 3 && inject == 2) begin
                start = 1; base_addr = 16'h0777;
            end
            prev_rdy = rdy; prev_addr = int'(out_addr);
            @(posedge clk);
            if (rdy) void'(q.pop_front());
            @(negedge clk);
            cfg_we = 0; start = 0;
            cyc++;
        end
        chk(q.size() == 0, "R5 count", expn - q.size(), expn);
        out_ready = 1;
        for (int i = 0; i < 3; i++) begin
            chk(out_valid == 0 && busy == 0, "R6 idle", out_valid, 0);
            @(negedge clk);
        end
        out_ready = 0;
    endtask

    task automatic cfg_a_blocks();
        write_dim(0, 2, 1);   // s=2, stride 1
        write_dim(1, 4, 8);   // r=4, stride k
        write_dim(2, 4, 2);   // k/s, stride s
        write_dim(3, 2, 32);  // m/r, stride r*k
    endtask

    initial begin
        for (int d = 0; d < 4; d++) begin m_wrap[d] = 0; m_stride[d] = 0; end
        repeat (3) @(negedge clk);
        chk(busy == 0 && out_valid == 0 && out_last == 0, "R1 reset", out_valid, 0);
        rst_n = 1;
        @(negedge clk);
        chk(busy == 0 && out_valid == 0, "R1 idle", busy, 0);

        cfg_a_blocks();
        run(100, 0, 0, "R3 A-blocks");
        run(100, 1, 0, "R4 stall");

        // k x n source with s x t blocks (k=n=8, s=2, t=4)
        write_dim(0, 4, 1);
        write_dim(1, 2, 8);
        write_dim(2, 2, 4);
        write_dim(3, 4, 16);
        run(0, 2, 0, "R3 B-blocks");

        // scatter r x t blocks into row-major m x n (m=n=8, r=4, t=4)
        write_dim(0, 4, 1);
        write_dim(1, 4, 8);
        write_dim(2, 2, 4);
        write_dim(3, 2, 32);
        run(512, 0, 0, "R3 C-scatter");

        // zero wraps disable the two outer dimensions
        write_dim(2, 0, 50);
        write_dim(3, 0, 70);
        run(20, 1, 0, "R7 zero-wrap");

        // configuration writes during a transfer are dropped
        cfg_a_blocks();
        run(40, 0, 1, "R8 cfg busy");
        run(40, 0, 0, "R8 cfg kept");

        // restart while busy has no effect
        run(200, 1, 2, "R9 restart");

        // addresses wrap at the top of the address space
        run(16'hFFF0, 0, 0, "R10 modulo");

        finish_run();
    end
endmodule